// File: doc/BRIEF.md
# Exchange Memory Access Controller

This block governs a dedicated exchange memory window that carries data between agents on a system bus, typically a shared dual-port RAM. It recognises the window from a fixed base address and a size code, drives one active-low chip select for every accepted access, and refuses any access narrower than a full word by raising an exception pulse. Nothing is sent to the memory for a refused access.

Each accepted access starts with a cycle that samples an active-low bus-ready input. After that it runs the programmed number of data wait states. When ready is withdrawn, the access holds where it is. An access that would run past 256 cycles is aborted by a bus timeout. Alongside the sequencing, the block produces a parity bit toward the processor. It generates odd parity over the read data when the memory keeps no check bits of its own. When check bits are present, it forwards the stored parity bit.

The size code, check-bits flag and wait-state count arrive as plain inputs from an external configuration register.

Top module: `xmem_ctrl`

## Requirements
- R1: The window starts at base XMEM_BASE (aligned to 512 KB) and spans 4 KB << sizeSel (sizeSel 0..7 gives 4 KB..512 KB; 0, the 4 KB minimum, is the reset default of the configuration). A request whose address lies outside the window produces no chip select, no done and no exception.
- R2: xmemCsN is the only chip select. It is low from the cycle after a word request is accepted through the cycle in which accDone is high, and high in every other cycle.
- R3: reqSize encodes 0 = byte, 1 = halfword, 2 = word (3 is treated as non-word). A non-word request inside the window raises accExc for exactly one cycle, in the cycle after the request, and never drives the chip select low.
- R4: The first chip-select cycle samples busReadyN. If busReadyN is high at the end of that cycle, the block stays in the sampling phase, and each such cycle lengthens the access by one.
- R5: With busReadyN held low, an access keeps the chip select low for exactly 3 + waitStates cycles (waitStates is 4 bits), so no access is shorter than 3 cycles.
- R6: Each cycle with busReadyN high during the wait-state phase holds the access and adds one cycle. The remaining wait states continue after ready returns.
- R7: If an access has held the chip select low for 256 cycles without completing, the chip select goes high in the next cycle, busErr pulses for that one cycle, and accDone is not raised.
- R8: With checkBitsOn low, cpuParity is odd parity over memRdata (high when memRdata has an even number of ones). With checkBitsOn high, cpuParity equals memParity.
- R9: A request presented while an access is in progress is ignored. It neither lengthens the access nor starts a second one.
- R10: accDone is a single-cycle pulse and at most one of accDone, accExc and busErr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | ADDR_W | Request byte address |
| reqSize | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| sizeSel | input | 3 | Window size code, 4 KB << sizeSel |
| checkBitsOn | input | 1 | Memory stores its own check bits |
| waitStates | input | 4 | Programmed data wait states |
| busReadyN | input | 1 | Active-low bus ready from the memory |
| memRdata | input | DATA_W | Read data from the exchange memory |
| memParity | input | 1 | Stored parity bit from the memory |
| xmemCsN | output | 1 | Active-low exchange memory chip select |
| accDone | output | 1 | Access completed pulse |
| accExc | output | 1 | Non-word access exception pulse |
| busErr | output | 1 | Bus timeout error pulse |
| cpuParity | output | 1 | Parity bit toward the processor |

## Verification
A request strobe seen at one edge shows up one cycle later. In that next cycle the chip select is low for an accepted word access, or accExc is high for a refused narrow one. From there, the chip select stays low for 3 + waitStates cycles plus one for every cycle with ready high, and accDone is high in the last of them. A timed-out access shows busErr in the first cycle after 256 low cycles. The bench drives ready for each access cycle just after the edge that opens that cycle and samples all outputs one nanosecond after each rising edge, which gives a per-cycle count of the chip-select window that is compared with these totals. Parity is combinational and is checked after a settle delay, with the expected bit taken from a ones count done in the bench.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_WAITS  = 2'd2,
    ST_LAST   = 2'd3
  } xmemState_t;

  typedef struct packed {
    logic waitLoad;
    logic waitDec;
    logic toClr;
    logic toInc;
  } xmemStrobes_t;

  localparam logic [1:0] SIZE_WORD = 2'd2;

endpackage

// File: rtl/xmem_datapath.sv
module xmem_datapath
  import xmem_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WS_W       = 4,
  parameter int MIN_SHIFT  = 12,
  parameter int NUM_SIZES  = 8,
  parameter int TIMEOUT    = 256,
  parameter logic [ADDR_W-1:0] XMEM_BASE = 32'h2000_0000,
  localparam int SEL_W     = $clog2(NUM_SIZES),
  localparam int MAX_SHIFT = MIN_SHIFT + NUM_SIZES - 1,
  localparam int TO_W      = $clog2(TIMEOUT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xmemStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic [WS_W-1:0]   waitStates,
  input  logic              checkBitsOn,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memParity,
  output logic              winHit,
  output logic              waitZero,
  output logic              toExpired,
  output logic              cpuParity
);

  logic [MAX_SHIFT-1:0] offset;
  logic                 baseMatch;
  logic [NUM_SIZES-1:0] sizeHit;
  logic [WS_W-1:0]      waitCnt;
  logic [TO_W-1:0]      toCnt;

  assign offset    = reqAddr[MAX_SHIFT-1:0];
  assign baseMatch = (reqAddr[ADDR_W-1:MAX_SHIFT] == XMEM_BASE[ADDR_W-1:MAX_SHIFT]);

  // one range check per selectable window size
  for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
    assign sizeHit[g] = ((offset >> (MIN_SHIFT + g)) == '0);
  end

  assign winHit = baseMatch && sizeHit[sizeSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.waitLoad) begin
      waitCnt <= waitStates;
    end else if (strobes.waitDec) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.toClr) begin
      toCnt <= '0;
    end else if (strobes.toInc) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  assign waitZero  = (waitCnt == '0);
  assign toExpired = (toCnt == TO_W'(TIMEOUT - 1));

  // odd parity when the memory has no check bits of its own
  assign cpuParity = checkBitsOn ? memParity : ~(^memRdata);

  AST_NO_WAIT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.waitDec |-> !waitZero);  // R6

  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.waitLoad && !strobes.waitDec) |=> $stable(waitCnt));  // R6

endmodule

// File: rtl/xmem_control.sv
module xmem_control
  import xmem_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqSize,
  input  logic         busReadyN,
  input  logic         winHit,
  input  logic         waitZero,
  input  logic         toExpired,
  output xmemStrobes_t strobes,
  output logic         xmemCsN,
  output logic         accDone,
  output logic         accExc,
  output logic         busErr
);

  xmemState_t state, stateNext;
  logic       isWord;
  logic       startAcc;
  logic       badSize;
  logic       timeoutNow;

  assign isWord     = (reqSize == SIZE_WORD);
  assign startAcc   = (state == ST_IDLE) && reqValid && winHit && isWord;
  assign badSize    = (state == ST_IDLE) && reqValid && winHit && !isWord;
  assign timeoutNow = ((state == ST_SAMPLE) || (state == ST_WAITS)) && toExpired;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startAcc) begin
          stateNext     = ST_SAMPLE;
          strobes.toClr = 1'b1;
        end
      end
      ST_SAMPLE: begin
        strobes.toInc = 1'b1;
        if (timeoutNow) begin
          stateNext = ST_IDLE;
        end else if (!busReadyN) begin
          stateNext        = ST_WAITS;
          strobes.waitLoad = 1'b1;
        end
      end
      ST_WAITS: begin
        strobes.toInc = 1'b1;
        if (timeoutNow) begin
          stateNext = ST_IDLE;
        end else if (!busReadyN) begin
          if (waitZero) stateNext = ST_LAST;
          else          strobes.waitDec = 1'b1;
        end
      end
      ST_LAST: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      accExc <= 1'b0;
      busErr <= 1'b0;
    end else begin
      state  <= stateNext;
      accExc <= badSize;
      busErr <= timeoutNow;
    end
  end

  assign xmemCsN = (state == ST_IDLE);
  assign accDone = (state == ST_LAST);

  AST_MIN_THREE: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> (!xmemCsN && !$past(xmemCsN) && !$past(xmemCsN, 2)));  // R5

  AST_EXC_NO_CS: assert property (@(posedge clk) disable iff (!rstN)
    accExc |-> xmemCsN);  // R3

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (xmemCsN && !$past(xmemCsN)));  // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> (xmemCsN && !accDone));  // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accDone, accExc, busErr}));  // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITS && busReadyN && !toExpired) |=> (state == ST_WAITS));  // R6

endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WS_W      = 4,
  parameter int MIN_SHIFT = 12,
  parameter int NUM_SIZES = 8,
  parameter int TIMEOUT   = 256,
  parameter logic [ADDR_W-1:0] XMEM_BASE = 32'h2000_0000,
  localparam int SEL_W    = $clog2(NUM_SIZES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic              checkBitsOn,
  input  logic [WS_W-1:0]   waitStates,
  input  logic              busReadyN,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memParity,
  output logic              xmemCsN,
  output logic              accDone,
  output logic              accExc,
  output logic              busErr,
  output logic              cpuParity
);

  xmemStrobes_t strobes;
  logic         winHit;
  logic         waitZero;
  logic         toExpired;

  xmem_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSize   (reqSize),
    .busReadyN (busReadyN),
    .winHit    (winHit),
    .waitZero  (waitZero),
    .toExpired (toExpired),
    .strobes   (strobes),
    .xmemCsN   (xmemCsN),
    .accDone   (accDone),
    .accExc    (accExc),
    .busErr    (busErr)
  );

  xmem_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WS_W      (WS_W),
    .MIN_SHIFT (MIN_SHIFT),
    .NUM_SIZES (NUM_SIZES),
    .TIMEOUT   (TIMEOUT),
    .XMEM_BASE (XMEM_BASE)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqAddr     (reqAddr),
    .sizeSel     (sizeSel),
    .waitStates  (waitStates),
    .checkBitsOn (checkBitsOn),
    .memRdata    (memRdata),
    .memParity   (memParity),
    .winHit      (winHit),
    .waitZero    (waitZero),
    .toExpired   (toExpired),
    .cpuParity   (cpuParity)
  );

endmodule

// File: tb/sim_xmem_ctrl.sv
module sim_xmem_ctrl;

  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'd2;
  logic [2:0]  sizeSel = 3'd0;
  logic        checkBitsOn = 1'b0;
  logic [3:0]  waitStates = 4'd0;
  logic        busReadyN = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memParity = 1'b0;
  logic        xmemCsN, accDone, accExc, busErr, cpuParity;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  xmem_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .sizeSel(sizeSel), .checkBitsOn(checkBitsOn),
    .waitStates(waitStates), .busReadyN(busReadyN), .memRdata(memRdata),
    .memParity(memParity), .xmemCsN(xmemCsN), .accDone(accDone),
    .accExc(accExc), .busErr(busErr), .cpuParity(cpuParity)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Issue a request and follow it. Ready is high in access cycles
  // [hiStart, hiStart+hiLen). A second request may be pulsed in cycle 2.
  task automatic runAccess(input logic [31:0] addr, input int hiStart,
                           input int hiLen, input bit extraReq,
                           output int csCycles, output int doneAt,
                           output int errAfter, output int doneCount);
    int cyc;
    csCycles = 0; doneAt = 0; errAfter = 0; doneCount = 0;
    reqAddr = addr; reqSize = 2'd2; reqValid = 1'b1;
    busReadyN = 1'b0;
    tick();
    reqValid = 1'b0;
    cyc = 1;
    while (xmemCsN == 1'b0 && cyc < 400) begin
      busReadyN = (cyc >= hiStart && cyc < hiStart + hiLen);
      if (extraReq && cyc == 2) reqValid = 1'b1;
      csCycles++;
      if (accDone) begin doneAt = cyc; doneCount++; end
      tick();
      reqValid = 1'b0;
      cyc++;
    end
    busReadyN = 1'b0;
    if (busErr) errAfter = 1;
  endtask

  task automatic quietCycles(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!xmemCsN || accDone || accExc || busErr) bad++;
      tick();
    end
    check(req, bad, 0);
  endtask

  task automatic testReset();
    check("R2 reset cs", xmemCsN, 1);
    check("R10 reset done", accDone, 0);
    check("R3 reset exc", accExc, 0);
    check("R7 reset err", busErr, 0);
  endtask

  task automatic testPlain(input int ws);
    int cs, da, ea, dc;
    waitStates = 4'(ws);
    runAccess(BASE + 32'h10, 0, 0, 1'b0, cs, da, ea, dc);
    check("R5 length", cs, 3 + ws);
    check("R2 done in last cs cycle", da, 3 + ws);
    check("R10 single done", dc, 1);
    check("R7 no err", ea, 0);
    tick();
  endtask

  task automatic testSampleHold(input int ws, input int k);
    int cs, da, ea, dc;
    waitStates = 4'(ws);
    runAccess(BASE + 32'h20, 1, k, 1'b0, cs, da, ea, dc);
    check("R4 sample hold length", cs, 3 + ws + k);
    check("R4 done position", da, 3 + ws + k);
    tick();
  endtask

  task automatic testMidStall(input int ws, input int m);
    int cs, da, ea, dc;
    waitStates = 4'(ws);
    runAccess(BASE + 32'h40, 3, m, 1'b0, cs, da, ea, dc);
    check("R6 mid stall length", cs, 3 + ws + m);
    check("R6 done once", dc, 1);
    tick();
  endtask

  task automatic testTimeout();
    int cs, da, ea, dc;
    waitStates = 4'd2;
    runAccess(BASE + 32'h80, 1, 1000, 1'b0, cs, da, ea, dc);
    check("R7 cs cycles before abort", cs, 256);
    check("R7 busErr after abort", ea, 1);
    check("R7 no done", dc, 0);
    check("R7 cs released", xmemCsN, 1);
    tick();
    check("R7 busErr one cycle", busErr, 0);
  endtask

  task automatic testNarrow(input logic [1:0] sz);
    reqAddr = BASE + 32'h100; reqSize = sz; reqValid = 1'b1;
    tick();
    reqValid = 1'b0; reqSize = 2'd2;
    check("R3 exception raised", accExc, 1);
    check("R3 no cs", xmemCsN, 1);
    tick();
    check("R3 exception one cycle", accExc, 0);
    quietCycles("R3 no access after refusal", 6);
  endtask

  task automatic testWindow();
    int cs, da, ea, dc;
    waitStates = 4'd0;
    sizeSel = 3'd0;
    reqAddr = BASE + 32'h1000; reqSize = 2'd2; reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    quietCycles("R1 past 4 KB ignored", 6);
    sizeSel = 3'd1;
    runAccess(BASE + 32'h1000, 0, 0, 1'b0, cs, da, ea, dc);
    check("R1 8 KB window hit", cs, 3);
    tick();
    sizeSel = 3'd7;
    runAccess(BASE + 32'h7_FFFC, 0, 0, 1'b0, cs, da, ea, dc);
    check("R1 512 KB top word hit", cs, 3);
    tick();
    reqAddr = BASE + 32'h8_0000; reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    quietCycles("R1 beyond 512 KB ignored", 6);
    reqAddr = 32'h1000_0000; reqSize = 2'd0; reqValid = 1'b1;
    tick();
    reqValid = 1'b0; reqSize = 2'd2;
    quietCycles("R1 narrow outside window no exception", 6);
    sizeSel = 3'd0;
  endtask

  task automatic testBusyIgnore();
    int cs, da, ea, dc;
    waitStates = 4'd3;
    runAccess(BASE + 32'h8, 0, 0, 1'b1, cs, da, ea, dc);
    check("R9 length unchanged", cs, 6);
    quietCycles("R9 no second access", 8);
  endtask

  function automatic int oddPar(input logic [31:0] d);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += d[i];
    return (ones % 2 == 0) ? 1 : 0;
  endfunction

  task automatic testParity();
    logic [31:0] pats [4] = '{32'h0, 32'h1, 32'hF0F0_0001, 32'hFFFF_FFFF};
    for (int i = 0; i < 4; i++) begin
      checkBitsOn = 1'b0; memRdata = pats[i]; memParity = 1'b1;
      #1;
      check("R8 generated odd parity", cpuParity, oddPar(pats[i]));
      checkBitsOn = 1'b1; memParity = ~oddPar(pats[i][31:0]) ? 1'b1 : 1'b0;
      #1;
      check("R8 forwarded parity", cpuParity, memParity);
    end
    checkBitsOn = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testPlain(0);
    testPlain(5);
    testPlain(15);
    testSampleHold(0, 1);
    testSampleHold(2, 4);
    testMidStall(2, 1);
    testMidStall(4, 3);
    testNarrow(2'd0);
    testNarrow(2'd1);
    testNarrow(2'd3);
    testWindow();
    testBusyIgnore();
    testTimeout();
    testParity();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule